// File: doc/BRIEF.md
# Registered-Macrocell Programmable Array Logic

This block models a small programmable array logic device. Its AND plane can be configured and its OR plane is fixed. Every product term may take any signal of the array in true form, in complemented form, or not at all. The signals are the external input pins plus one feedback line from each macrocell. Each macrocell ORs only its own fixed group of product terms.

The macrocell holds a D flip-flop that samples that sum on the rising clock edge. A mode bit chooses whether the pin shows the live sum or the stored bit. The output is then gated by a per-pin enable. The multiplexer result is fed back into the AND plane, so one configured array can build multi-level logic and state machines.

Configuration arrives as a serial bit stream while a load strobe is high. The flip-flops clear on reset, and the loaded configuration survives reset.

Top module: `pal_array`

## Requirements
- R1: While `prog_en` is high, each rising edge shifts `prog_din` into configuration bit CFG_W-1 and moves every bit one place toward bit 0. The first bit of a CFG_W-bit load therefore ends at bit 0.
- R2: While `prog_en` is low, the configuration is unchanged whatever `prog_din` does.
- R3: Array signal i is `pin_in[i]` for i < N_IN, and the feedback of macrocell i-N_IN above that. Term t (macrocell t/N_PT, slot t%N_PT) owns configuration bits starting at N_MC + t*2*(N_IN+N_MC). In that range, bit 2i selects signal i true and bit 2i+1 selects it complemented. A term is the AND of its selected literals.
- R4: A product term with no literal selected evaluates to 0.
- R5: Macrocell k ORs only terms k*N_PT through k*N_PT+N_PT-1.
- R6: Each macrocell flip-flop samples its OR result on every rising edge out of reset. When configuration bit k is 1, pin k shows that flip-flop.
- R7: When configuration bit k is 0, pin k shows the live OR result of macrocell k.
- R8: Feedback of macrocell j, as seen by macrocell k, is j's multiplexer output when j < k. For j >= k it is j's flip-flop value.
- R9: `pin_oe[k]` equals `oe_in[k]`. A disabled pin shows `pin_val[k]` = 0, while its feedback still carries the multiplexer value.
- R10: `rst_n` low clears all flip-flops at once and leaves the configuration intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous flip-flop clear |
| prog_en | input | 1 | Configuration shift enable |
| prog_din | input | 1 | Serial configuration bit |
| pin_in | input | N_IN | External input pins |
| oe_in | input | N_MC | Per-pin output enables |
| pin_val | output | N_MC | Pin value, 0 when disabled |
| pin_oe | output | N_MC | Pin drive enable; low means high impedance |

## Verification
The bench goes after the literal layout and the shift order. A reversed chain or swapped polarity bits would turn a known AND-with-complement into a different function. It drives empty terms and neighbouring groups, where a term defaulting to 1 or leaking into the next macrocell would raise pins that must stay low.

A toggle machine runs with its pin disabled. That exposes feedback gated by the output enable, and a downstream combinational cell that reads the stored bit instead of the live one. A reset in the middle of a run checks that the flip-flops clear at once while the configuration still produces the same functions. Long runs with `prog_din` toggling and the load strobe low catch a chain that shifts when it should not.

// File: rtl/pal_pkg.sv
package pal_pkg;

  function automatic int lit_count(input int n_in, input int n_mc);
    return n_in + n_mc;
  endfunction

  function automatic int group_width(input int n_in, input int n_mc, input int n_pt);
    return n_pt * 2 * lit_count(n_in, n_mc);
  endfunction

  function automatic int cfg_width(input int n_in, input int n_mc, input int n_pt);
    return n_mc + n_mc * group_width(n_in, n_mc, n_pt);
  endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] bits
);

  logic [W-1:0] bits_nxt;

  always_comb begin
    bits_nxt = bits;
    if (shift_en) begin
      bits_nxt = {din, bits[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      bits <= bits_nxt;
    end
  end

endmodule

// File: rtl/pal_state_reg.sv
module pal_state_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/pal_term_group.sv
module pal_term_group #(
  parameter int N_LIT = 12,
  parameter int N_PT  = 4,
  localparam int TW   = 2 * N_LIT,
  localparam int FW   = N_PT * TW
) (
  input  logic [N_LIT-1:0] sig,
  input  logic [FW-1:0]    fuse,
  output logic             or_out
);

  logic [N_PT-1:0] hit;

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_LIT-1:0] use_t;
    logic [N_LIT-1:0] use_c;
    for (genvar i = 0; i < N_LIT; i++) begin : g_lit
      assign use_t[i] = fuse[p*TW + 2*i];
      assign use_c[i] = fuse[p*TW + 2*i + 1];
    end
    assign hit[p] = (|(use_t | use_c))
                  & ~(|(use_t & ~sig))
                  & ~(|(use_c & sig));
  end

  assign or_out = |hit;

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell (
  input  logic reg_sel,
  input  logic ff_q,
  input  logic or_in,
  input  logic oe,
  output logic mux_out,
  output logic pin_val,
  output logic pin_oe
);

  always_comb begin
    mux_out = reg_sel ? ff_q : or_in;
    pin_oe  = oe;
    pin_val = oe & mux_out;
  end

endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_MC = 4,
  parameter int N_PT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_en,
  input  logic            prog_din,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_MC-1:0] oe_in,
  output logic [N_MC-1:0] pin_val,
  output logic [N_MC-1:0] pin_oe
);

  localparam int N_LIT = lit_count(N_IN, N_MC);
  localparam int GRP_W = group_width(N_IN, N_MC, N_PT);
  localparam int CFG_W = cfg_width(N_IN, N_MC, N_PT);

  logic [CFG_W-1:0] cfg_bits;
  logic [N_MC-1:0]  reg_sel;
  logic [N_MC-1:0]  ff_q;
  logic [N_MC-1:0]  or_vec;

  pal_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .shift_en (prog_en),
    .din      (prog_din),
    .bits     (cfg_bits)
  );

  assign reg_sel = cfg_bits[N_MC-1:0];

  pal_state_reg #(.N(N_MC)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (or_vec),
    .q     (ff_q)
  );

  // Stage k sees live values of lower macrocells, stored values of the rest.
  for (genvar k = 0; k < N_MC; k++) begin : g_mc
    logic [N_MC-1:0]  fb_in;
    logic [N_MC-1:0]  fb_out;
    logic [N_LIT-1:0] sig;
    logic             or_bit;
    logic             mux_bit;

    if (k == 0) begin : g_head
      assign fb_in = ff_q;
    end else begin : g_link
      assign fb_in = g_mc[k-1].fb_out;
    end

    assign sig = {fb_in, pin_in};

    pal_term_group #(.N_LIT(N_LIT), .N_PT(N_PT)) u_terms (
      .sig    (sig),
      .fuse   (cfg_bits[N_MC + k*GRP_W +: GRP_W]),
      .or_out (or_bit)
    );

    pal_macrocell u_cell (
      .reg_sel (reg_sel[k]),
      .ff_q    (ff_q[k]),
      .or_in   (or_bit),
      .oe      (oe_in[k]),
      .mux_out (mux_bit),
      .pin_val (pin_val[k]),
      .pin_oe  (pin_oe[k])
    );

    always_comb begin
      fb_out    = fb_in;
      fb_out[k] = mux_bit;
    end

    assign or_vec[k] = or_bit;
  end

endmodule

// File: rtl/pal_checks.sv
module pal_checks #(
  parameter int N_MC  = 4,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_en,
  input logic             prog_din,
  input logic [CFG_W-1:0] cfg_bits,
  input logic [N_MC-1:0]  or_vec,
  input logic [N_MC-1:0]  ff_q,
  input logic [N_MC-1:0]  oe_in,
  input logic [N_MC-1:0]  pin_val
);

  logic [N_MC-1:0] mode_reg;
  assign mode_reg = cfg_bits[N_MC-1:0];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> cfg_bits[CFG_W-1] == $past(prog_din)); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(cfg_bits)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ff_q == '0); // R10

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ff_q == $past(or_vec)); // R6

  AST_REG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_val ^ (ff_q & oe_in)) & mode_reg) == '0); // R6

  AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_val & ~oe_in) == '0); // R9

endmodule

bind pal_array pal_checks #(.N_MC(N_MC), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .prog_en  (prog_en),
  .prog_din (prog_din),
  .cfg_bits (cfg_bits),
  .or_vec   (or_vec),
  .ff_q     (ff_q),
  .oe_in    (oe_in),
  .pin_val  (pin_val)
);

// File: tb/tb_pal_array.sv
module tb_pal_array;

  localparam int N_IN       = 8;
  localparam int N_MC       = 4;
  localparam int N_PT       = 4;
  localparam int N_LIT      = N_IN + N_MC;
  localparam int CFG_W      = N_MC + N_MC * N_PT * 2 * N_LIT;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            prog_en;
  logic            prog_din;
  logic [N_IN-1:0] pin_in;
  logic [N_MC-1:0] oe_in;
  logic [N_MC-1:0] pin_val;
  logic [N_MC-1:0] pin_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_array #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_din(prog_din),
    .pin_in(pin_in), .oe_in(oe_in), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [CFG_W-1:0] m_cfg;
  logic [N_MC-1:0]  m_q;

  // Returns {next flip-flop values, multiplexer values}.
  function automatic logic [2*N_MC-1:0] eval(input logic [CFG_W-1:0] c,
                                              input logic [N_IN-1:0] in,
                                              input logic [N_MC-1:0] q);
    logic [N_MC-1:0] ors = '0;
    logic [N_MC-1:0] mux = '0;
    for (int k = 0; k < N_MC; k++) begin
      logic [N_MC-1:0]  fb = q;
      logic [N_LIT-1:0] s;
      for (int j = 0; j < k; j++) fb[j] = mux[j];
      s = {fb, in};
      for (int p = 0; p < N_PT; p++) begin
        int  base = N_MC + (k*N_PT + p) * 2 * N_LIT;
        bit  any  = 1'b0;
        bit  all  = 1'b1;
        for (int i = 0; i < N_LIT; i++) begin
          if (c[base + 2*i])     begin any = 1'b1; if (!s[i]) all = 1'b0; end
          if (c[base + 2*i + 1]) begin any = 1'b1; if (s[i])  all = 1'b0; end
        end
        if (any && all) ors[k] = 1'b1;
      end
      mux[k] = c[k] ? q[k] : ors[k];
    end
    return {ors, mux};
  endfunction

  function automatic logic [CFG_W-1:0] with_lit(input logic [CFG_W-1:0] c,
                                                 input int mc, input int p,
                                                 input int s, input bit comp);
    c[N_MC + (mc*N_PT + p) * 2 * N_LIT + 2*s + int'(comp)] = 1'b1;
    return c;
  endfunction

  task automatic check(input string tag, input logic [N_MC-1:0] got_v,
                       input logic [N_MC-1:0] exp_v, input logic [N_MC-1:0] got_oe,
                       input logic [N_MC-1:0] exp_oe);
    checks++;
    if (got_v !== exp_v || got_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: pin_val=%b exp %b pin_oe=%b exp %b", tag, got_v, exp_v, got_oe, exp_oe);
    end
  endtask

  task automatic load_cfg(input logic [CFG_W-1:0] c);
    prog_en = 1'b1;
    for (int i = 0; i < CFG_W; i++) begin
      prog_din = c[i];
      @(posedge clk);
      #1;
    end
    @(negedge clk);
    prog_en = 1'b0;
    m_cfg   = c;
  endtask

  task automatic step(input string tag);
    logic [2*N_MC-1:0] r;
    #2;
    r = eval(m_cfg, pin_in, m_q);
    check(tag, pin_val, r[N_MC-1:0] & oe_in, pin_oe, oe_in);
    @(posedge clk);
    m_q = r[2*N_MC-1:N_MC];
    @(negedge clk);
  endtask

  task automatic fresh(input logic [CFG_W-1:0] c);
    rst_n = 1'b0;
    m_q   = '0;
    load_cfg(c);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    logic [CFG_W-1:0] c;
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    rst_n = 1'b0; prog_en = 1'b0; prog_din = 1'b0;
    pin_in = '0; oe_in = '1; m_q = '0;
    repeat (2) @(negedge clk);

    // Reset state, all terms empty: R10, R4
    load_cfg('0);
    #2 check("R10 R4 reset state", pin_val, '0, pin_oe, '1);
    @(negedge clk);

    // Directed layout: mc0 = in0 & ~in1, mc1 = in2, mc2/mc3 empty
    c = '0;
    c = with_lit(c, 0, 0, 0, 1'b0);
    c = with_lit(c, 0, 0, 1, 1'b1);
    c = with_lit(c, 1, 0, 2, 1'b0);
    fresh(c);
    for (int v = 0; v < 16; v++) begin
      logic [N_MC-1:0] e;
      pin_in = N_IN'($urandom) & ~N_IN'(7);
      pin_in[2:0] = v[2:0];
      oe_in  = '1;
      #2;
      e = {2'b00, pin_in[2], pin_in[0] & ~pin_in[1]};
      check("R1 R3 R4 R5 R7 layout", pin_val, e, pin_oe, '1);
      @(negedge clk);
    end

    // Feedback: mc0 reg toggles, mc1 comb = fb0, mc2 comb = fb3, mc3 reg = in0
    c = '0;
    c[0] = 1'b1; c[3] = 1'b1;
    c = with_lit(c, 0, 0, N_IN + 0, 1'b1);
    c = with_lit(c, 1, 2, N_IN + 0, 1'b0);
    c = with_lit(c, 2, 3, N_IN + 3, 1'b0);
    c = with_lit(c, 3, 1, 0, 1'b0);
    fresh(c);
    for (int n = 0; n < 10; n++) begin
      pin_in = N_IN'($urandom);
      oe_in  = 4'b1110;
      #1;
      check("R8 R9 hidden toggle feeds mc1", pin_val & 4'b0011, {2'b00, n[0], 1'b0},
            pin_oe, 4'b1110);
      step("R6 R8 R9 feedback");
    end

    // Random configurations and traffic
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < CFG_W; i++) c[i] = ($urandom % 10 == 0);
      c[N_MC-1:0] = N_MC'($urandom);
      fresh(c);
      for (int n = 0; n < 40; n++) begin
        pin_in = N_IN'($urandom);
        oe_in  = N_MC'($urandom);
        step("R3 R5 R6 R7 R8 R9 random");
      end
    end

    // Load strobe low: prog_din activity ignored (R2)
    for (int n = 0; n < 30; n++) begin
      pin_in   = N_IN'($urandom);
      oe_in    = N_MC'($urandom);
      prog_din = 1'($urandom);
      step("R2 config hold");
    end

    // Mid-run reset: flip-flops clear at once, config kept (R10)
    oe_in = '1;
    rst_n = 1'b0;
    m_q   = '0;
    #2 check("R10 async clear", pin_val, eval(m_cfg, pin_in, '0) >> 0 & {N_MC{1'b1}},
             pin_oe, '1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 12; n++) begin
      pin_in = N_IN'($urandom);
      oe_in  = N_MC'($urandom);
      step("R10 config retained");
    end

    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      summary();
    end
  end

endmodule